// File: doc/BRIEF.md
# Fetch Return Instruction Unpacker

This block sits between an instruction-fetch memory port and the per-wavefront instruction buffers. A fetch response arrives as a burst of 32-bit words. It carries the wavefront slot that issued the fetch and a length in words. The block walks the words one instruction per cycle. Bit 31 of an instruction's first word selects its length: one word or two. For each instruction it writes one instruction-buffer entry tagged with the slot and stamped with a global sequence number.

The block also keeps two flags per slot. The first is a pending-fetch flag, set when a fetch is issued and cleared once its response has been processed. The second is a discard flag, set when a fetch in flight has gone stale. If the discard flag is set when the response is accepted, the response data is thrown away, the discard flag is cleared and the pending flag is cleared. No entry is written and no sequence number is used.

The controller is a four-state machine:
- `S_IDLE` accepts a response.
- `S_WALK` emits one instruction per cycle.
- `S_FINISH` retires an accepted response.
- `S_DROP` retires a discarded one.

The transitions are:
- IDLE→DROP when the slot's discard flag is set.
- IDLE→FINISH when the length is zero.
- IDLE→WALK otherwise.
- WALK→WALK while words remain.
- WALK→FINISH when the walk index reaches the length.
- FINISH→IDLE and DROP→IDLE unconditionally.

Top module: `fetch_unpacker`

## Requirements
- R1: After reset, `rsp_ready` is 1, `ib_wr_valid` is 0, all `pending` and `drop_pend` bits are 0, and the first entry written carries sequence number 0.
- R2: A word with bit 31 set starts an 8-byte instruction. Its entry has `ib_wr_long`=1 and `ib_wr_inst` = {next word, this word}, and it consumes two words. A word with bit 31 clear gives `ib_wr_long`=0 and `ib_wr_inst` = {32'b0, word}, and it consumes one word.
- R3: Entries are written one per cycle, in word order from word 0 (bits 31:0 of `rsp_data`) upward, each tagged with the response slot on `ib_wr_slot`.
- R4: Each written entry carries the current sequence number. The number then increments by one and wraps modulo 2^SEQW.
- R5: The walk covers exactly `rsp_len` words, with values above MAXW clamped to MAXW. A zero-length response writes no entry.
- R6: An 8-byte instruction whose second word lies beyond the response length is not written.
- R7: If the slot's `drop_pend` bit is 1 at acceptance, no entry is written, the sequence number is unchanged, and that bit reads 0 once `rsp_ready` returns to 1.
- R8: Once a response has been processed (accepted or discarded), the slot's `pending` bit is 0. Other slots' bits are unchanged.
- R9: `issue_valid` sets `pending[issue_slot]` on the next cycle, and `drop_valid` sets `drop_pend[drop_slot]`. A set wins over a clear in the same cycle.
- R10: `rsp_ready` is low from the cycle after acceptance until processing ends. This lasts one cycle per walk step plus one, or exactly one cycle for a discarded response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| issue_valid | input | 1 | a fetch was issued for `issue_slot` |
| issue_slot | input | SW | slot of the issued fetch |
| drop_valid | input | 1 | mark the in-flight fetch of `drop_slot` as stale |
| drop_slot | input | SW | slot to mark |
| rsp_valid | input | 1 | fetch response present |
| rsp_ready | output | 1 | block can accept a response |
| rsp_slot | input | SW | slot the response belongs to |
| rsp_len | input | LW | response length in 32-bit words |
| rsp_data | input | MAXW*32 | response words, word 0 in the low bits |
| ib_wr_valid | output | 1 | instruction-buffer write strobe |
| ib_wr_slot | output | SW | buffer slot written |
| ib_wr_inst | output | 64 | instruction bits |
| ib_wr_long | output | 1 | entry is an 8-byte instruction |
| ib_wr_seq | output | SEQW | sequence number of the entry |
| pending | output | NSLOT | per-slot pending-fetch flags |
| drop_pend | output | NSLOT | per-slot discard flags |

## Verification
The hardest situation to reach is a long instruction whose second word lies past the end of the response (R6). It needs bit 31 set exactly in the last counted word. Random words rarely produce this together with a short length. Directed responses therefore place a long marker in the final word, at lengths 1 and MAXW. The sequence wrap is reached by building the bench with a narrow sequence counter and sending enough random responses to pass 2^SEQW entries. Discards are interleaved with accepted responses so that the sequence number is seen to skip nothing.

// File: rtl/fu_pkg.sv
package fu_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_WALK   = 2'd1,
        S_FINISH = 2'd2,
        S_DROP   = 2'd3
    } fu_state_e;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned LONG_BIT = 31;
endpackage

// File: rtl/fu_seq_counter.sv
module fu_seq_counter #(
    parameter int unsigned SEQW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bump,
    output logic [SEQW-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value <= '0;
        else if (bump) value <= value + 1'b1;
    end

    // R4: every stamped entry advances the counter by exactly one
    a_r4_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> value == $past(value) + 1'b1);
    a_r4_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(value));
endmodule

// File: rtl/fu_slot_flags.sv
module fu_slot_flags #(
    parameter int unsigned NSLOT = 4,
    localparam int unsigned SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_pend,
    input  logic [SW-1:0]    set_pend_slot,
    input  logic             set_drop,
    input  logic [SW-1:0]    set_drop_slot,
    input  logic             clr_pend,
    input  logic             clr_drop,
    input  logic [SW-1:0]    clr_slot,
    output logic [NSLOT-1:0] pend_q,
    output logic [NSLOT-1:0] drop_q
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
                drop_q[g] <= 1'b0;
            end else begin
                if (set_pend && set_pend_slot == SW'(g)) pend_q[g] <= 1'b1;
                else if (clr_pend && clr_slot == SW'(g)) pend_q[g] <= 1'b0;
                if (set_drop && set_drop_slot == SW'(g)) drop_q[g] <= 1'b1;
                else if (clr_drop && clr_slot == SW'(g)) drop_q[g] <= 1'b0;
            end
        end
    end

    // R8: a clear without a competing set leaves the flag low
    a_r8_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend && !(set_pend && set_pend_slot == clr_slot) |=> !pend_q[$past(clr_slot)]);
    // R9: a set is visible on the next cycle
    a_r9_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_pend |=> pend_q[$past(set_pend_slot)]);
    a_r9_drop_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_drop |=> drop_q[$past(set_drop_slot)]);
endmodule

// File: rtl/fu_word_picker.sv
module fu_word_picker #(
    parameter int unsigned MAXW = 8,
    localparam int unsigned IW = $clog2(MAXW + 2)
) (
    input  logic [MAXW*32-1:0] words,
    input  logic [IW-1:0]      idx,
    input  logic [IW-1:0]      len,
    output logic [31:0]        first_w,
    output logic [31:0]        second_w,
    output logic               is_long,
    output logic               fits,
    output logic [IW-1:0]      next_idx
);
    logic [MAXW*32+31:0] shifted;

    always_comb begin
        shifted  = {32'b0, words} >> ({{(32-IW){1'b0}}, idx} * 32);
        first_w  = shifted[31:0];
        second_w = shifted[63:32];
        is_long  = first_w[fu_pkg::LONG_BIT];
        fits     = (idx + IW'(1)) < len;
        next_idx = idx + (is_long ? IW'(2) : IW'(1));
    end
endmodule

// File: rtl/fetch_unpacker.sv
module fetch_unpacker #(
    parameter int unsigned NSLOT = 4,
    parameter int unsigned MAXW  = 8,
    parameter int unsigned SEQW  = 16,
    localparam int unsigned SW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int unsigned LW = $clog2(MAXW + 1),
    localparam int unsigned IW = $clog2(MAXW + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [SW-1:0]      issue_slot,
    input  logic               drop_valid,
    input  logic [SW-1:0]      drop_slot,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [SW-1:0]      rsp_slot,
    input  logic [LW-1:0]      rsp_len,
    input  logic [MAXW*32-1:0] rsp_data,
    output logic               ib_wr_valid,
    output logic [SW-1:0]      ib_wr_slot,
    output logic [63:0]        ib_wr_inst,
    output logic               ib_wr_long,
    output logic [SEQW-1:0]    ib_wr_seq,
    output logic [NSLOT-1:0]   pending,
    output logic [NSLOT-1:0]   drop_pend
);
    import fu_pkg::*;

    fu_state_e           state, state_nx;
    logic [SW-1:0]       cur_slot;
    logic [IW-1:0]       cur_len;
    logic [IW-1:0]       idx;
    logic [MAXW*32-1:0]  cur_data;
    logic [31:0]         w0, w1;
    logic                is_long, fits;
    logic [IW-1:0]       next_idx;
    logic [IW-1:0]       len_clamped;
    logic                clr_pend, clr_drop, accept;

    assign accept      = rsp_valid && rsp_ready;
    assign len_clamped = ({{(IW-LW){1'b0}}, rsp_len} > IW'(MAXW)) ? IW'(MAXW)
                                                                   : {{(IW-LW){1'b0}}, rsp_len};

    fu_word_picker #(.MAXW(MAXW)) u_pick (
        .words(cur_data), .idx(idx), .len(cur_len),
        .first_w(w0), .second_w(w1), .is_long(is_long),
        .fits(fits), .next_idx(next_idx)
    );

    fu_seq_counter #(.SEQW(SEQW)) u_seq (
        .clk(clk), .rst_n(rst_n), .bump(ib_wr_valid), .value(ib_wr_seq)
    );

    fu_slot_flags #(.NSLOT(NSLOT)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_pend(issue_valid), .set_pend_slot(issue_slot),
        .set_drop(drop_valid), .set_drop_slot(drop_slot),
        .clr_pend(clr_pend), .clr_drop(clr_drop), .clr_slot(cur_slot),
        .pend_q(pending), .drop_q(drop_pend)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (drop_pend[rsp_slot])       state_nx = S_DROP;
                    else if (len_clamped == '0)    state_nx = S_FINISH;
                    else                           state_nx = S_WALK;
                end
            end
            S_WALK:   if (next_idx >= cur_len) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            S_DROP:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_slot <= '0;
            cur_len  <= '0;
            idx      <= '0;
            cur_data <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && accept) begin
                cur_slot <= rsp_slot;
                cur_len  <= len_clamped;
                cur_data <= rsp_data;
                idx      <= '0;
            end else if (state == S_WALK) begin
                idx <= next_idx;
            end
        end
    end

    // outputs
    always_comb begin
        rsp_ready   = 1'b0;
        ib_wr_valid = 1'b0;
        ib_wr_slot  = cur_slot;
        ib_wr_inst  = '0;
        ib_wr_long  = 1'b0;
        clr_pend    = 1'b0;
        clr_drop    = 1'b0;
        unique case (state)
            S_IDLE: rsp_ready = 1'b1;
            S_WALK: begin
                ib_wr_valid = !is_long || fits;
                ib_wr_long  = is_long;
                ib_wr_inst  = is_long ? {w1, w0} : {32'b0, w0};
            end
            S_FINISH: clr_pend = 1'b1;
            S_DROP: begin
                clr_pend = 1'b1;
                clr_drop = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: the walk never points at or past the response end
    a_r5_walk_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_WALK |-> idx < cur_len);
    // R6: a long entry always has both words inside the response
    a_r6_long_inside: assert property (@(posedge clk) disable iff (!rst_n)
        ib_wr_valid && ib_wr_long |-> (idx + IW'(1)) < cur_len);
    // R7: a discarded response is never followed by a write
    a_r7_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_DROP |=> !ib_wr_valid);
    // R10: after an accept the port is busy on the next cycle
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !rsp_ready);
endmodule

// File: tb/fetch_unpacker_tb.sv
module fetch_unpacker_tb;
    localparam int NSLOT = 4;
    localparam int MAXW  = 8;
    localparam int SEQW  = 6;
    localparam int SW    = 2;
    localparam int LW    = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               issue_valid = 0, drop_valid = 0, rsp_valid = 0;
    logic [SW-1:0]      issue_slot = 0, drop_slot = 0, rsp_slot = 0;
    logic [LW-1:0]      rsp_len = 0;
    logic [MAXW*32-1:0] rsp_data = '0;
    logic               rsp_ready, ib_wr_valid, ib_wr_long;
    logic [SW-1:0]      ib_wr_slot;
    logic [63:0]        ib_wr_inst;
    logic [SEQW-1:0]    ib_wr_seq;
    logic [NSLOT-1:0]   pending, drop_pend;

    int total = 0, bad = 0;
    int exp_seq = 0;
    logic [31:0] wd [MAXW];

    always #4 clk = ~clk;

    fetch_unpacker #(.NSLOT(NSLOT), .MAXW(MAXW), .SEQW(SEQW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_slot(issue_slot),
        .drop_valid(drop_valid), .drop_slot(drop_slot),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_slot(rsp_slot),
        .rsp_len(rsp_len), .rsp_data(rsp_data),
        .ib_wr_valid(ib_wr_valid), .ib_wr_slot(ib_wr_slot),
        .ib_wr_inst(ib_wr_inst), .ib_wr_long(ib_wr_long), .ib_wr_seq(ib_wr_seq),
        .pending(pending), .drop_pend(drop_pend)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected entry k of a response: returns walk steps and entry count
    function automatic void model(input int len, output int steps, output int n,
                                  output logic [63:0] inst [MAXW], output bit lng [MAXW]);
        int i = 0;
        int l = (len > MAXW) ? MAXW : len;
        steps = 0; n = 0;
        while (i < l) begin
            steps++;
            if (wd[i][31]) begin
                if (i + 1 < l) begin
                    inst[n] = {wd[i+1], wd[i]}; lng[n] = 1; n++;
                end
                i += 2;
            end else begin
                inst[n] = {32'b0, wd[i]}; lng[n] = 0; n++;
                i += 1;
            end
        end
    endfunction

    task automatic issue(input int slot);
        @(negedge clk);
        issue_valid = 1; issue_slot = SW'(slot);
        @(negedge clk);
        issue_valid = 0;
        chk(pending[slot] == 1'b1, "R9 pending set", pending, 1 << slot);
    endtask

    task automatic mark_drop(input int slot);
        @(negedge clk);
        drop_valid = 1; drop_slot = SW'(slot);
        @(negedge clk);
        drop_valid = 0;
        chk(drop_pend[slot] == 1'b1, "R9 drop set", drop_pend, 1 << slot);
    endtask

    task automatic send(input int slot, input int len);
        logic [63:0] inst [MAXW];
        bit lng [MAXW];
        int steps, n, got = 0, busy = 0;
        bit dropping = drop_pend[slot];
        logic [NSLOT-1:0] pend_before = pending;
        logic [NSLOT-1:0] drop_before = drop_pend;
        model(len, steps, n, inst, lng);
        for (int k = 0; k < MAXW; k++) rsp_data[k*32 +: 32] = wd[k];
        rsp_slot = SW'(slot); rsp_len = LW'(len); rsp_valid = 1;
        @(negedge clk);
        rsp_valid = 0;
        while (!rsp_ready && busy < 40) begin
            busy++;
            if (ib_wr_valid) begin
                if (dropping || got >= n) begin
                    chk(0, "R7 unexpected write", got, n);
                end else begin
                    chk(ib_wr_inst == inst[got], "R2 inst", ib_wr_inst, inst[got]);
                    chk(ib_wr_long == lng[got], "R2 long", ib_wr_long, lng[got]);
                    chk(ib_wr_slot == SW'(slot), "R3 slot", ib_wr_slot, slot);
                    chk(ib_wr_seq == SEQW'(exp_seq), "R4 seq", ib_wr_seq, exp_seq % (1 << SEQW));
                    exp_seq++;
                end
                got++;
            end
            @(negedge clk);
        end
        if (dropping) begin
            chk(got == 0, "R7 no entry", got, 0);
            chk(busy == 1, "R10 drop busy", busy, 1);
            chk(drop_pend == (drop_before & ~(NSLOT'(1) << slot)), "R7 drop clear", drop_pend,
                drop_before & ~(NSLOT'(1) << slot));
        end else begin
            chk(got == n, "R5 R6 entry count", got, n);
            chk(busy == steps + 1, "R10 busy cycles", busy, steps + 1);
        end
        chk(pending == (pend_before & ~(NSLOT'(1) << slot)), "R8 pending clear", pending,
            pend_before & ~(NSLOT'(1) << slot));
    endtask

    task automatic rand_words();
        for (int k = 0; k < MAXW; k++) begin
            wd[k] = $urandom;
            wd[k][31] = ($urandom % 3) == 0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rsp_ready == 1, "R1 ready", rsp_ready, 1);
        chk(ib_wr_valid == 0, "R1 no write", ib_wr_valid, 0);
        chk(pending == 0 && drop_pend == 0, "R1 flags", {pending, drop_pend}, 0);

        // R1 R2 short then long, first entry seq 0
        wd[0] = 32'h0000_0011; wd[1] = 32'h8000_0022; wd[2] = 32'h1234_5678;
        for (int k = 3; k < MAXW; k++) wd[k] = 32'h0000_0100 + k;
        issue(1);
        send(1, 3);
        // R5 zero length
        issue(2);
        send(2, 0);
        // R6 truncated long at length 1 and at MAXW
        wd[0] = 32'h8000_00aa;
        issue(0);
        send(0, 1);
        for (int k = 0; k < MAXW - 1; k++) wd[k] = 32'h0000_0200 + k;
        wd[MAXW-1] = 32'hc000_0001;
        issue(3);
        send(3, MAXW);
        // R5 clamp of an oversize length
        rand_words();
        issue(3);
        send(3, 15);
        // R7 discard then accepted response keeps sequence
        rand_words();
        issue(2);
        mark_drop(2);
        send(2, 5);
        rand_words();
        issue(2);
        send(2, 4);
        // random mix, passes the sequence wrap (R4)
        for (int t = 0; t < 60; t++) begin
            int s = $urandom % NSLOT;
            rand_words();
            issue(s);
            if (($urandom % 5) == 0) mark_drop(s);
            send(s, $urandom % (MAXW + 1));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule